// File: doc/BRIEF.md
# Dual-Width General-Purpose Register File

This block holds the integer working registers of a 64-bit core. It has thirty-one 64-bit registers, two combinational read ports and one clocked write port. Each port has its own width select. The wide setting moves all 64 bits. The narrow setting works on the low 32 bits only: a narrow read returns the low half with the upper half forced to zero, and a narrow write stores the low half and clears the upper half.

Index 31 is not a storage register. Each port has a mode bit that says how that index is decoded. With the mode bit low, index 31 is a constant zero: it reads as zero and writes to it are dropped. With the mode bit high, index 31 reaches a stack pointer. There is one stack pointer for each privilege level, and the current level input picks which one. The decoder drives the mode bit high only for the arithmetic forms that may touch the stack pointer. The program counter is kept elsewhere and cannot be reached through any index.

Writes take effect on the clock edge, so a read in the same cycle sees the value the register held before that edge.

Top module: `dualwidth_regfile`

## Requirements
- R1: After reset, every register and every banked stack pointer reads as zero.
- R2: A wide write to index 0..30 stores all 64 bits, and a wide read of that index on a later cycle returns them unchanged.
- R3: A narrow read (width select 0) returns the low 32 bits of the selected source on bits 31:0 and zero on bits 63:32.
- R4: A narrow write to index 0..30 stores data bits 31:0 and sets the upper 32 bits of the register to zero.
- R5: With the port's mode bit at 0, index 31 reads as zero, and a write to it changes no register and no stack pointer.
- R6: With the port's mode bit at 1, index 31 selects the stack pointer of the current level (0..3). A write there changes only that level's stack pointer.
- R7: A narrow write to a stack pointer zero-extends the low 32 bits, and a narrow read of a stack pointer returns its low half.
- R8: A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle on.
- R9: The two read ports are independent: each port applies its own index, width and mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| level | input | 2 | Current privilege level, selects the banked stack pointer |
| rdIdxA | input | 5 | Read port A index |
| rdWideA | input | 1 | Read port A width: 1 = 64 bits, 0 = 32 bits |
| rdSpA | input | 1 | Read port A index-31 mode: 1 = stack pointer, 0 = zero |
| rdDataA | output | 64 | Read port A data |
| rdIdxB | input | 5 | Read port B index |
| rdWideB | input | 1 | Read port B width: 1 = 64 bits, 0 = 32 bits |
| rdSpB | input | 1 | Read port B index-31 mode: 1 = stack pointer, 0 = zero |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Write index |
| wrWide | input | 1 | Write width: 1 = 64 bits, 0 = 32 bits |
| wrSp | input | 1 | Write index-31 mode: 1 = stack pointer, 0 = zero |
| wrData | input | 64 | Write data |

## Verification
The case that is hardest to reach from the ports is a stack pointer write whose effect has to be told apart from the other banks and from the zero alias. To see it, the same level must later be read with the stack pointer mode set, and the other levels must be read to show they did not change. The random stimulus draws the level, the three mode bits and the widths on their own, and it draws indices from a small pool that includes 31 often. This makes repeated hits on the same register and on the same bank at different widths common. Directed sequences then preload all-ones patterns, so that a dropped zero-extension or a write that leaks into the wrong bank shows up in the upper bits.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DATA_W     = 64;
  localparam int RF_NUM_GPR    = 31;
  localparam int RF_IDX_W      = 5;
  localparam int RF_NUM_LEVELS = 4;
  localparam int RF_LVL_W      = $clog2(RF_NUM_LEVELS);
  localparam int RF_NUM_RD     = 2;

  typedef enum logic [1:0] {
    SRC_GPR  = 2'd0,
    SRC_SP   = 2'd1,
    SRC_ZERO = 2'd2
  } rdSrc_t;

  typedef struct packed {
    rdSrc_t                src;
    logic [RF_IDX_W-1:0]   idx;
    logic [RF_LVL_W-1:0]   lvl;
    logic                  narrow;
  } rdStrobe_t;

  typedef struct packed {
    logic                     gprWe;
    logic [RF_IDX_W-1:0]      gprIdx;
    logic [RF_NUM_LEVELS-1:0] spWe;
    logic                     narrow;
  } wrStrobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_GPR    = RF_NUM_GPR,
  parameter int IDX_W      = RF_IDX_W,
  parameter int NUM_LEVELS = RF_NUM_LEVELS,
  parameter int NUM_RD     = RF_NUM_RD,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic [LVL_W-1:0]             level,
  input  logic [NUM_RD-1:0][IDX_W-1:0] rdIdx,
  input  logic [NUM_RD-1:0]            rdWide,
  input  logic [NUM_RD-1:0]            rdSp,
  input  logic                         wrEn,
  input  logic [IDX_W-1:0]             wrIdx,
  input  logic                         wrWide,
  input  logic                         wrSp,
  output rdStrobe_t [NUM_RD-1:0]       rdStb,
  output wrStrobe_t                    wrStb
);
  // The index just above the last storage register is the alias slot.
  localparam logic [IDX_W-1:0] ALIAS_IDX = IDX_W'(NUM_GPR);

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdDecode
    always_comb begin
      rdStb[p].idx    = rdIdx[p];
      rdStb[p].lvl    = level;
      rdStb[p].narrow = !rdWide[p];
      if (rdIdx[p] < ALIAS_IDX)
        rdStb[p].src = SRC_GPR;
      else if (rdIdx[p] == ALIAS_IDX && rdSp[p])
        rdStb[p].src = SRC_SP;
      else
        rdStb[p].src = SRC_ZERO;
    end
  end

  always_comb begin
    wrStb.gprWe  = wrEn && (wrIdx < ALIAS_IDX);
    wrStb.gprIdx = wrIdx;
    wrStb.narrow = !wrWide;
    wrStb.spWe   = '0;
    if (wrEn && wrSp && wrIdx == ALIAS_IDX)
      wrStb.spWe[level] = 1'b1;
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W     = RF_DATA_W,
  parameter int NUM_GPR    = RF_NUM_GPR,
  parameter int NUM_LEVELS = RF_NUM_LEVELS,
  parameter int NUM_RD     = RF_NUM_RD,
  localparam int HALF_W    = DATA_W / 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rdStrobe_t [NUM_RD-1:0]        rdStb,
  input  wrStrobe_t                     wrStb,
  input  logic [DATA_W-1:0]             wrData,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] gprQ [NUM_GPR];
  logic [DATA_W-1:0] spQ  [NUM_LEVELS];
  logic [DATA_W-1:0] wrVal;

  // Narrow writes keep the low half and clear the rest.
  assign wrVal = wrStb.narrow ? {{HALF_W{1'b0}}, wrData[HALF_W-1:0]} : wrData;

  for (genvar r = 0; r < NUM_GPR; r++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        gprQ[r] <= '0;
      else if (wrStb.gprWe && wrStb.gprIdx == r)
        gprQ[r] <= wrVal;
    end
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_sp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        spQ[l] <= '0;
      else if (wrStb.spWe[l])
        spQ[l] <= wrVal;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdMux
    logic [DATA_W-1:0] rawVal;
    always_comb begin
      unique case (rdStb[p].src)
        SRC_GPR: rawVal = gprQ[rdStb[p].idx];
        SRC_SP:  rawVal = spQ[rdStb[p].lvl];
        default: rawVal = '0;
      endcase
      rdData[p] = rdStb[p].narrow ? {{HALF_W{1'b0}}, rawVal[HALF_W-1:0]} : rawVal;
    end
  end
endmodule

// File: rtl/dualwidth_regfile.sv
module dualwidth_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W     = RF_DATA_W,
  parameter int NUM_GPR    = RF_NUM_GPR,
  parameter int IDX_W      = RF_IDX_W,
  parameter int NUM_LEVELS = RF_NUM_LEVELS,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  level,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic              rdWideA,
  input  logic              rdSpA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              rdWideB,
  input  logic              rdSpB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrWide,
  input  logic              wrSp,
  input  logic [DATA_W-1:0] wrData
);
  localparam int NUM_RD = RF_NUM_RD;

  rdStrobe_t [NUM_RD-1:0]        rdStb;
  wrStrobe_t                     wrStb;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  rf_ctrl #(
    .NUM_GPR(NUM_GPR), .IDX_W(IDX_W), .NUM_LEVELS(NUM_LEVELS), .NUM_RD(NUM_RD)
  ) u_ctrl (
    .level (level),
    .rdIdx ({rdIdxB, rdIdxA}),
    .rdWide({rdWideB, rdWideA}),
    .rdSp  ({rdSpB, rdSpA}),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .wrWide(wrWide),
    .wrSp  (wrSp),
    .rdStb (rdStb),
    .wrStb (wrStb)
  );

  rf_datapath #(
    .DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .NUM_LEVELS(NUM_LEVELS), .NUM_RD(NUM_RD)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .rdStb (rdStb),
    .wrStb (wrStb),
    .wrData(wrData),
    .rdData(rdData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 5,
  parameter int NUM_GPR    = 31,
  parameter int LVL_W      = 2,
  localparam int HALF_W    = DATA_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [LVL_W-1:0]  level,
  input logic [IDX_W-1:0]  rdIdxA,
  input logic              rdWideA,
  input logic              rdSpA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [IDX_W-1:0]  rdIdxB,
  input logic              rdWideB,
  input logic              rdSpB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              wrWide,
  input logic              wrSp,
  input logic [DATA_W-1:0] wrData
);
  localparam logic [IDX_W-1:0] ALIAS_IDX = IDX_W'(NUM_GPR);

  // R3
  narrow_read_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdWideA |-> rdDataA[DATA_W-1:HALF_W] == '0);

  // R9
  narrow_read_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdWideB |-> rdDataB[DATA_W-1:HALF_W] == '0);

  // R5
  zero_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == ALIAS_IDX && !rdSpA) |-> rdDataA == '0);

  // R2
  wide_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWide && wrIdx != ALIAS_IDX) |=>
      (!(rdIdxA == $past(wrIdx) && rdWideA) || rdDataA == $past(wrData)));

  // R4
  narrow_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrWide && wrIdx != ALIAS_IDX) |=>
      (!(rdIdxA == $past(wrIdx) && rdWideA) ||
       rdDataA == {{HALF_W{1'b0}}, $past(wrData[HALF_W-1:0])}));

  // R6
  sp_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWide && wrSp && wrIdx == ALIAS_IDX) |=>
      (!(rdIdxA == ALIAS_IDX && rdSpA && rdWideA && level == $past(level)) ||
       rdDataA == $past(wrData)));
endmodule

bind dualwidth_regfile rf_checker #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_GPR(NUM_GPR), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .level(level),
  .rdIdxA(rdIdxA), .rdWideA(rdWideA), .rdSpA(rdSpA), .rdDataA(rdDataA),
  .rdIdxB(rdIdxB), .rdWideB(rdWideB), .rdSpB(rdSpB), .rdDataB(rdDataB),
  .wrEn(wrEn), .wrIdx(wrIdx), .wrWide(wrWide), .wrSp(wrSp), .wrData(wrData)
);

// File: tb/tb_dualwidth_regfile.sv
module tb_dualwidth_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  level = '0;
  logic [4:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic        rdWideA = 1'b1, rdWideB = 1'b1, rdSpA = 1'b0, rdSpB = 1'b0;
  logic        wrEn = 1'b0, wrWide = 1'b1, wrSp = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdDataA, rdDataB;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mGpr [31];
  logic [63:0] mSp  [4];

  // 50 MHz: 20 ns period
  always #10 clk = ~clk;

  dualwidth_regfile dut (
    .clk(clk), .rstN(rstN), .level(level),
    .rdIdxA(rdIdxA), .rdWideA(rdWideA), .rdSpA(rdSpA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdWideB(rdWideB), .rdSpB(rdSpB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrWide(wrWide), .wrSp(wrSp), .wrData(wrData)
  );

  function automatic logic [63:0] expRead(input logic [4:0] idx, input logic wide,
                                          input logic sp, input logic [1:0] lvl);
    logic [63:0] v;
    if (idx < 5'd31)  v = mGpr[idx];
    else if (sp)      v = mSp[lvl];
    else              v = '0;
    if (!wide) v = {32'h0, v[31:0]};
    return v;
  endfunction

  task automatic modelWrite();
    logic [63:0] v;
    if (!wrEn) return;
    v = wrWide ? wrData : {32'h0, wrData[31:0]};
    if (wrIdx < 5'd31)  mGpr[wrIdx] = v;
    else if (wrSp)      mSp[level] = v;
  endtask

  task automatic checkVal(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check reads mid-low phase, apply write at rise.
  task automatic cycle(input string tag, input logic we, input logic [4:0] wi,
                       input logic ww, input logic ws, input logic [63:0] wd,
                       input logic [4:0] ia, input logic wa, input logic sa,
                       input logic [4:0] ib, input logic wb, input logic sb,
                       input logic [1:0] lv);
    @(negedge clk);
    wrEn = we; wrIdx = wi; wrWide = ww; wrSp = ws; wrData = wd;
    rdIdxA = ia; rdWideA = wa; rdSpA = sa;
    rdIdxB = ib; rdWideB = wb; rdSpB = sb; level = lv;
    #5;
    checkVal(tag, "port A", rdDataA, expRead(ia, wa, sa, lv));
    checkVal(tag, "port B", rdDataB, expRead(ib, wb, sb, lv));
    @(posedge clk);
    modelWrite();
    #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] ia, input logic wa,
                    input logic sa, input logic [1:0] lv);
    cycle(tag, 1'b0, 5'd0, 1'b1, 1'b0, 64'h0, ia, wa, sa, ia, 1'b1, sa, lv);
  endtask

  task automatic wr(input string tag, input logic [4:0] wi, input logic ww,
                    input logic ws, input logic [63:0] wd, input logic [1:0] lv);
    cycle(tag, 1'b1, wi, ww, ws, wd, 5'd0, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1, lv);
  endtask

  initial begin
    #4000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 31; i++) mGpr[i] = '0;
    for (int l = 0; l < 4; l++) mSp[l] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and every bank
    for (int i = 0; i < 31; i++) rd("R1", 5'(i), 1'b1, 1'b0, 2'd0);
    for (int l = 0; l < 4; l++) rd("R1", 5'd31, 1'b1, 1'b1, 2'(l));

    // R2: wide round trip
    wr("R2", 5'd0, 1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567, 2'd0);
    wr("R2", 5'd30, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1);
    rd("R2", 5'd0, 1'b1, 1'b0, 2'd0);
    rd("R2", 5'd30, 1'b1, 1'b0, 2'd2);

    // R3: narrow read of an all-ones register
    rd("R3", 5'd30, 1'b0, 1'b0, 2'd0);

    // R4: narrow write over all-ones clears upper half
    wr("R4", 5'd30, 1'b0, 1'b0, 64'hAAAA_AAAA_1234_5678, 2'd0);
    rd("R4", 5'd30, 1'b1, 1'b0, 2'd0);

    // R6: each bank gets its own value; then read all banks
    for (int l = 0; l < 4; l++)
      wr("R6", 5'd31, 1'b1, 1'b1, {16'hF0F0, 8'(l), 40'hFF_FFFF_FFFF}, 2'(l));
    for (int l = 0; l < 4; l++) rd("R6", 5'd31, 1'b1, 1'b1, 2'(l));

    // R5: zero alias write must leave banks and registers alone
    for (int l = 0; l < 4; l++) begin
      wr("R5", 5'd31, 1'b1, 1'b0, 64'h1111_2222_3333_4444, 2'(l));
      rd("R5", 5'd31, 1'b1, 1'b1, 2'(l));
      rd("R5", 5'd31, 1'b1, 1'b0, 2'(l));
    end
    rd("R5", 5'd0, 1'b1, 1'b0, 2'd0);

    // R7: narrow stack pointer write and read
    wr("R7", 5'd31, 1'b0, 1'b1, 64'h9999_8888_7654_3210, 2'd2);
    rd("R7", 5'd31, 1'b1, 1'b1, 2'd2);
    rd("R7", 5'd31, 1'b0, 1'b1, 2'd3);
    rd("R7", 5'd31, 1'b1, 1'b1, 2'd1);

    // R8: same-cycle write and read of one register
    cycle("R8", 1'b1, 5'd7, 1'b1, 1'b0, 64'h0BAD_F00D_CAFE_0001,
          5'd7, 1'b1, 1'b0, 5'd7, 1'b0, 1'b0, 2'd0);
    rd("R8", 5'd7, 1'b1, 1'b0, 2'd0);
    cycle("R8", 1'b1, 5'd31, 1'b1, 1'b1, 64'h5555_6666_7777_8888,
          5'd31, 1'b1, 1'b1, 5'd31, 1'b1, 1'b1, 2'd0);
    rd("R8", 5'd31, 1'b1, 1'b1, 2'd0);

    // R9: the two ports with different settings in one cycle
    cycle("R9", 1'b0, 5'd0, 1'b1, 1'b0, 64'h0,
          5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0);
    cycle("R9", 1'b0, 5'd0, 1'b1, 1'b0, 64'h0,
          5'd31, 1'b1, 1'b1, 5'd31, 1'b1, 1'b0, 2'd3);

    // Random mix; the tag follows the read case on port A
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] pool [6];
      logic [4:0] ia, ib, wi;
      logic wa, sa, ws;
      string tag;
      pool = '{5'd0, 5'd3, 5'd17, 5'd30, 5'd31, 5'd31};
      ia = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : pool[$urandom_range(0, 5)];
      ib = pool[$urandom_range(0, 5)];
      wi = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : pool[$urandom_range(0, 5)];
      wa = 1'($urandom_range(0, 1));
      sa = 1'($urandom_range(0, 1));
      ws = 1'($urandom_range(0, 1));
      if (ia == 5'd31 && !sa)     tag = "R5";
      else if (ia == 5'd31 && !wa) tag = "R7";
      else if (ia == 5'd31)       tag = "R6";
      else if (!wa)               tag = "R3";
      else if (ia == wi)          tag = "R8";
      else                        tag = "R2";
      cycle(tag, 1'($urandom_range(0, 1)), wi, 1'($urandom_range(0, 1)), ws,
            {$urandom(), $urandom()}, ia, wa, sa,
            ib, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)));
    end

    // R4: final sweep after random traffic
    for (int i = 0; i < 31; i++) rd("R4", 5'(i), 1'b1, 1'b0, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule